// File: doc/BRIEF.md
# PWM Generator with Queued Duty Samples

This block produces a pulse-width modulated output whose high time comes from a small queue of duty samples. Firmware sets the period length through a level input and pushes duty samples through a one-cycle write strobe. A counter steps through the period once per clock and starts over at its end. The output is high from the first count of each period until the counter reaches the duty sample that is in use.

Samples are taken from the queue only at period boundaries, one per boundary. This covers a sample written while the queue is empty: it waits for the running period to end like any other. A smaller duty value that arrives mid-period therefore cannot skip the falling edge and hold the output high for a whole period. Firmware can read the counter value, the queue occupancy, a sticky flag for dropped writes, and a flag that compares occupancy against a 2-bit watermark setting.

Top module: `dutyq_pwm`

## Requirements
- R1: With enable high, `count_o` advances by one per clock through 0 .. P-1, where P is `period_i`, and returns to 0 after P-1. If P is 0 or 1, or if the counter is at or above P-1 because the period was shortened, the counter goes to 0 at the next edge.
- R2: `pwm_o` is 1 exactly when enable is high and `count_o` is below the duty sample in use. A sample of 0 keeps the output low. A sample of P or more keeps it high for the whole period.
- R3: Each write strobe queues `wr_data_i`. At each counter wrap the oldest queued sample becomes the sample in use if the queue is not empty. Otherwise the previous sample stays in use.
- R4: A sample written mid-period, even into an empty queue, never changes the running period. The old sample governs until the wrap.
- R5: `fill_o` gives the number of queued samples, 0 to 4. Four back-to-back writes into an empty queue are all kept.
- R6: A write to a full queue is dropped unless a pop happens on the same edge, in which case it is kept. A dropped write sets `ovf_o`, which stays 1 until reset.
- R7: While enable is low, the counter is held at 0, the output is low and nothing is popped, but writes are still queued. After enable rises, the period starts at count 0.
- R8: `low_o` is 1 exactly when `fill_o` is less than or equal to the 2-bit value `wmark_i`.
- R9: After reset the counter is 0, the sample in use is 0, the queue is empty, `ovf_o` is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| period_i | input | 16 | Period length in clocks |
| wr_i | input | 1 | Strobe that queues one duty sample |
| wr_data_i | input | 16 | Duty sample to queue |
| wmark_i | input | 2 | Occupancy watermark setting |
| count_o | output | 16 | Current counter value |
| fill_o | output | 3 | Number of queued samples |
| ovf_o | output | 1 | Sticky dropped-write flag |
| low_o | output | 1 | Occupancy at or below the watermark |
| pwm_o | output | 1 | PWM output |

## Verification
The main function is tried over every combination of period 1 to 6 and duty sample 0 to 7. This separates the always-low, partial-duty and always-high cases, as well as the degenerate single-cycle period, against an arithmetic model checked every cycle. A dedicated pattern writes a smaller sample mid-period into an empty queue after the counter has passed it. This tells a design that defers the sample apart from one that applies it at once and loses the falling edge. Further patterns shorten the period below the current count, fill the queue while disabled, write on a full queue with and without a simultaneous pop, and sweep the watermark through all four settings. These separate the wrap, drop and occupancy rules from one another.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int DQ_CNT_W = 16;
    localparam int DQ_DEPTH = 4;

    // per-edge queue events
    typedef struct packed {
        logic tick;
        logic pop;
        logic push;
        logic drop;
    } dq_evt_t;

    // true on the final count of a period; periods of 0 or 1 wrap every clock
    function automatic logic at_last(input logic [31:0] cnt, input logic [31:0] per);
        if (per <= 32'd1) return 1'b1;
        return cnt >= (per - 32'd1);
    endfunction

endpackage

// File: rtl/dq_fifo.sv
module dq_fifo
    import dq_pkg::*;
#(
    parameter int W     = DQ_CNT_W,
    parameter int DEPTH = DQ_DEPTH,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [W-1:0]  push_data,
    input  logic          pop_req,
    output logic [W-1:0]  head,
    output logic          not_empty,
    output logic [FW-1:0] fill,
    output logic          ovf
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [FW-1:0] fill_q;
    logic          ovf_q;
    logic          full;
    dq_evt_t       ev;
    logic [FW-1:0] wpos;

    assign full      = (32'(fill_q) == DEPTH);
    assign not_empty = (fill_q != '0);

    always_comb begin
        ev      = '0;
        ev.pop  = pop_req && not_empty;
        ev.push = push_req && (!full || ev.pop);
        ev.drop = push_req && !ev.push;
        wpos    = fill_q - FW'(ev.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            fill_q <= fill_q + FW'(ev.push) - FW'(ev.pop);
            if (ev.drop) ovf_q <= 1'b1;
        end
    end

    // shifting storage: entry 0 is always the oldest sample
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= '0;
            end else begin
                if (ev.pop) begin
                    if (i + 1 < DEPTH) mem_q[i] <= mem_q[(i + 1) % DEPTH];
                end
                if (ev.push && 32'(wpos) == i) mem_q[i] <= push_data;
            end
        end
    end

    assign head = mem_q[0];
    assign fill = fill_q;
    assign ovf  = ovf_q;

    a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
        32'(fill_q) <= DEPTH);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    a_r6_drop_keeps_fill: assert property (@(posedge clk) disable iff (rst)
        (push_req && full && !pop_req) |=> (fill_q == $past(fill_q)) && ovf_q);

endmodule

// File: rtl/dq_counter.sv
module dq_counter
    import dq_pkg::*;
#(
    parameter int W = DQ_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign tick = en && at_last(32'(cnt_q), 32'(period));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (!en)  cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/dq_shaper.sv
module dq_shaper
    import dq_pkg::*;
#(
    parameter int W = DQ_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic         have_next,
    input  logic [W-1:0] next_sample,
    input  logic [W-1:0] cnt,
    output logic         pwm
);

    logic [W-1:0] act_q;

    // sample in use changes only at a period boundary
    always_ff @(posedge clk) begin
        if (rst)                    act_q <= '0;
        else if (tick && have_next) act_q <= next_sample;
    end

    assign pwm = en && (cnt < act_q);

    a_r3_take_head: assert property (@(posedge clk) disable iff (rst)
        (tick && have_next) |=> (act_q == $past(next_sample)));

    a_r4_no_midperiod_change: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_q));

    a_r2_zero_low: assert property (@(posedge clk) disable iff (rst)
        (act_q == '0) |-> !pwm);

    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm);

endmodule

// File: rtl/dutyq_pwm.sv
module dutyq_pwm
    import dq_pkg::*;
#(
    parameter int W     = DQ_CNT_W,
    parameter int DEPTH = DQ_DEPTH,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [W-1:0]  period_i,
    input  logic          wr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [1:0]    wmark_i,
    output logic [W-1:0]  count_o,
    output logic [FW-1:0] fill_o,
    output logic          ovf_o,
    output logic          low_o,
    output logic          pwm_o
);

    logic         tick;
    logic         have_next;
    logic [W-1:0] head;

    dq_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en_i),
        .period (period_i),
        .cnt    (count_o),
        .tick   (tick)
    );

    dq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_i),
        .push_data (wr_data_i),
        .pop_req   (tick),
        .head      (head),
        .not_empty (have_next),
        .fill      (fill_o),
        .ovf       (ovf_o)
    );

    dq_shaper #(.W(W)) u_shape (
        .clk         (clk),
        .rst         (rst),
        .en          (en_i),
        .tick        (tick),
        .have_next   (have_next),
        .next_sample (head),
        .cnt         (count_o),
        .pwm         (pwm_o)
    );

    assign low_o = (32'(fill_o) <= 32'(wmark_i));

    a_r8_low_flag: assert property (@(posedge clk) disable iff (rst)
        (fill_o == '0) |-> low_o);

endmodule

// File: tb/dutyq_pwm_test.sv
module dutyq_pwm_test;

    localparam int W  = 16;
    localparam int D  = 4;
    localparam int FW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          wr = 1'b0;
    logic [W-1:0]  per = 16'd8;
    logic [W-1:0]  wdat = '0;
    logic [1:0]    wm = 2'd0;
    logic [W-1:0]  count_o;
    logic [FW-1:0] fill_o;
    logic          ovf_o, low_o, pwm_o;

    dutyq_pwm uut (
        .clk(clk), .rst(rst), .en_i(en), .period_i(per), .wr_i(wr),
        .wr_data_i(wdat), .wmark_i(wm), .count_o(count_o), .fill_o(fill_o),
        .ovf_o(ovf_o), .low_o(low_o), .pwm_o(pwm_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // arithmetic model of the requirements
    int m_cnt = 0, m_act = 0, m_fill = 0, m_ovf = 0;
    int mq [D];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R1 count", int'(count_o), m_cnt);
        chk("R2 pwm", int'(pwm_o), (en && m_cnt < m_act) ? 1 : 0);
        chk("R5 fill", int'(fill_o), m_fill);
        chk("R6 ovf", int'(ovf_o), m_ovf);
        chk("R8 low", int'(low_o), (m_fill <= int'(wm)) ? 1 : 0);
    endtask

    // one clock: model computed from pre-edge inputs, compared 1 ns after the edge
    task automatic cyc();
        int p, last, tick, pop, push;
        p    = int'(per);
        last = (p <= 1 || m_cnt >= p - 1) ? 1 : 0;
        tick = (en && last) ? 1 : 0;
        pop  = (tick && m_fill > 0) ? 1 : 0;
        push = (wr && (m_fill < D || pop)) ? 1 : 0;
        @(posedge clk);
        #1;
        if (rst) begin
            m_cnt = 0; m_act = 0; m_fill = 0; m_ovf = 0;
        end else begin
            if (wr && !push) m_ovf = 1;
            m_cnt = (!en || tick) ? 0 : m_cnt + 1;
            if (pop) begin
                m_act = mq[0];
                for (int i = 0; i < D - 1; i++) mq[i] = mq[i + 1];
                m_fill--;
            end
            if (push) begin
                mq[m_fill] = int'(wdat);
                m_fill++;
            end
        end
        cmp_all();
        wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; wr = 1'b0;
        cyc();
        cyc();
        rst = 1'b0;
    endtask

    task automatic push_val(input int v);
        wdat = W'(v);
        wr = 1'b1;
        cyc();
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 count", int'(count_o), 0);
        chk("R9 fill", int'(fill_o), 0);
        chk("R9 ovf", int'(ovf_o), 0);
        chk("R9 pwm", int'(pwm_o), 0);

        // R1 R2 R3: sweep period and sample
        en = 1'b1;
        for (int p = 1; p <= 6; p++) begin
            for (int s = 0; s <= 7; s++) begin
                per = W'(p);
                push_val(s);
                repeat (2 * p + 2) cyc();
            end
        end

        // R1: shortening the period below the count wraps at once
        per = 16'd10;
        repeat (25) cyc();
        while (count_o != 16'd7) cyc();
        per = 16'd3;
        cyc();
        chk("R1 shrink wrap", int'(count_o), 0);
        repeat (6) cyc();

        // R4: smaller sample into empty queue after counter passed it
        do_reset();
        per = 16'd10;
        push_val(6);
        en = 1'b1;
        while (count_o != 16'd9) cyc();
        cyc();
        chk("R3 new sample taken", int'(pwm_o), 1);
        while (count_o != 16'd5) cyc();
        push_val(2);
        while (count_o != 16'd0) begin
            chk("R4 old sample holds", int'(pwm_o), (count_o < 16'd6) ? 1 : 0);
            cyc();
        end
        repeat (10) begin
            chk("R3 deferred sample", int'(pwm_o), (count_o < 16'd2) ? 1 : 0);
            cyc();
        end

        // R7 R5: fill while disabled, no pops, output low
        do_reset();
        per = 16'd4;
        for (int i = 0; i < 4; i++) push_val(i + 1);
        repeat (5) cyc();
        chk("R5 four kept", int'(fill_o), 4);
        chk("R7 idle count", int'(count_o), 0);
        chk("R7 idle pwm", int'(pwm_o), 0);
        // R8: every watermark setting at fill 4 and after draining
        for (int k = 0; k < 4; k++) begin
            wm = 2'(k);
            #1;
            chk("R8 wmark full", int'(low_o), 0);
        end
        // R6: write with pop on same edge is kept
        per = 16'd1;
        en = 1'b1;
        push_val(9);
        chk("R6 push with pop", int'(fill_o), 4);
        chk("R6 no ovf", int'(ovf_o), 0);
        repeat (6) cyc();
        chk("R3 last sample kept", int'(fill_o), 0);
        for (int k = 0; k < 4; k++) begin
            wm = 2'(k);
            #1;
            chk("R8 wmark empty", int'(low_o), 1);
        end
        // R6: overflow while disabled
        en = 1'b0;
        for (int i = 0; i < 5; i++) push_val(i + 3);
        chk("R6 drop fill", int'(fill_o), 4);
        chk("R6 ovf set", int'(ovf_o), 1);
        wm = 2'd2;
        per = 16'd5;
        en = 1'b1;
        repeat (30) cyc();
        chk("R6 ovf sticky", int'(ovf_o), 1);
        // R7: enable restarts at zero
        en = 1'b0;
        cyc();
        en = 1'b1;
        cyc();
        chk("R7 restart", int'(count_o), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule